// File: doc/BRIEF.md
# Sixteen-Bit Timer Channel with Capture and Compare

This block is one counter channel of a general-purpose timer. An up-counter advances on a count tick. The tick comes from the system clock divided by 1, 4, 16 or 64, or from an edge on one of two external event inputs. The counter runs in one of two ways. In free-running mode it wraps from all-ones to zero and raises an overflow flag. In periodic mode a chosen general register's compare match returns it to zero on the next tick.

There is a bank of four general registers. Each one is set up on its own as either a compare register or a capture register. A compare register raises a match flag when the counter reaches its value, and it drives a pin with a chosen action. A capture register copies the counter value on a selected edge of its input pin and raises its flag. Software sets the channel up through a small register port. The usual order is: choose the clock and edge, choose the clear source, put that register in compare mode, load the period, and then write the start bit.

A three-state controller (`ST_HALT`, `ST_FREE`, `ST_CYCLE`) makes run and mode decisions. It takes transition GO_FREE from halt to free when start is written 1 and no valid clear source is selected. It takes GO_CYCLE from halt to cycle when start is written 1 and a valid clear source is selected. It takes STOP from either running state back to halt when start is written 0. It takes RESELECT between free and cycle when the clear source is changed while running.

Top module: `tmr_channel`

## Requirements
- R1: After reset the counter reads 0, every flag reads 0, every compare pin is low and the channel is halted.
- R2: The counter advances by one on each count tick only while the start bit (bit 0 of address 1) is 1. After start is written 0 it holds its value.
- R3: Clock select (bits 2:0 of address 0) values 0, 1, 2 and 3 give one tick per 1, 4, 16 or 64 clocks. The divider restarts from zero at each start.
- R4: Clock select 4 counts edges of ext_clk[0] and 5 counts edges of ext_clk[1]. The edge field (bits 4:3 of address 0) selects the edge: 0 rising, 1 falling, 2 or 3 both. Any other select value gives no ticks.
- R5: Clear select (bits 7:5 of address 0) value k in 1..4 makes a match on general register k-1 return the counter to 0 on that tick, so the period is value+1 ticks. Value 0 gives free-running counting.
- R6: A tick at 0xFFFF that is not a clear wraps the counter to 0 and sets the overflow flag (bit 15 of address 2).
- R7: A general register in compare mode sets its flag (bit i of address 2) on a tick taken while the counter equals its value.
- R8: On a match, the compare pin follows config bits 2:1 of address 8+i: 00 hold, 01 drive low, 10 drive high, 11 toggle.
- R9: Config bit 0 = 1 selects capture mode, and bits 2:1 select the capture edge: 01 rising, 10 falling, 11 both, 00 none. On that edge of cap_in[i] the counter value is copied into the register (address 4+i) and its flag is set.
- R10: A flag clears only when 0 is written to its bit after a read of address 2 has returned it as 1. A write made without such a read leaves the flag unchanged.
- R11: The control register at address 0 reads back as written. Address 3 reads and writes the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr |
| ext_clk | input | 2 | External count clock / event inputs |
| cap_in | input | 4 | Capture trigger pins, one per general register |
| cmp_out | output | 4 | Compare-match output pins, one per general register |

## Verification
A register write takes effect at the clock edge that samples it. A counter tick changes the counter one edge after the tick is generated, and the first tick after a start falls one edge after the start is sampled. External and capture pins pass through a two-stage synchronizer and an edge detector, so their effect is visible three edges after the pin moves. Each check therefore waits at least five clocks after a pin change before reading. Timed count runs use an exact count of tick edges between the sampled start and the sampled stop (k+2 for k idle clocks between the two writes). The bench drives on falling edges and samples there, and it reads results only once the channel is halted or the pins have settled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_START    = 4'd1;
    localparam logic [ADDR_W-1:0] A_FLAGS    = 4'd2;
    localparam logic [ADDR_W-1:0] A_COUNT    = 4'd3;
    localparam logic [ADDR_W-1:0] A_VAL_BASE = 4'd4;
    localparam logic [ADDR_W-1:0] A_CFG_BASE = 4'd8;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_FREE  = 2'd1,
        ST_CYCLE = 2'd2
    } run_state_t;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } cmp_act_t;
endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            armed  <= 1'b0;
        end else begin
            if (set_i)
                flag_o <= 1'b1;
            else if (wr_i && !wbit_i && armed)
                flag_o <= 1'b0;

            if (rd_i)
                armed <= flag_o;
            else if (wr_i)
                armed <= 1'b0;
        end
    end

    // R10: a flag that was never read as set cannot be cleared
    p_blind_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !armed) |=> flag_o);
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int N_EXT    = 2,
    parameter int PRE_LOG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [2:0]       clk_sel,
    input  logic [1:0]       edge_sel,
    input  logic [N_EXT-1:0] ext_clk,
    output logic             tick
);
    localparam int N_INT = 4;
    localparam int DIV_W = PRE_LOG * (N_INT - 1);

    logic [DIV_W-1:0] div;
    logic [N_INT-1:0] int_tick;
    logic [N_EXT-1:0] s1, s2, prev, ext_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div <= '0;
        else if (!run)
            div <= '0;
        else
            div <= div + 1'b1;
    end

    generate
        for (genvar k = 0; k < N_INT; k++) begin : g_int
            if (k == 0) begin : g_direct
                assign int_tick[k] = run;
            end else begin : g_divided
                assign int_tick[k] = run && (&div[k*PRE_LOG-1:0]);
            end
        end

        for (genvar e = 0; e < N_EXT; e++) begin : g_ext
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s1[e]   <= 1'b0;
                    s2[e]   <= 1'b0;
                    prev[e] <= 1'b0;
                end else begin
                    s1[e]   <= ext_clk[e];
                    s2[e]   <= s1[e];
                    prev[e] <= s2[e];
                end
            end

            always_comb begin
                unique case (edge_sel)
                    2'b00:   ext_evt[e] = s2[e] && !prev[e];
                    2'b01:   ext_evt[e] = !s2[e] && prev[e];
                    default: ext_evt[e] = s2[e] ^ prev[e];
                endcase
            end
        end
    endgenerate

    always_comb begin
        tick = 1'b0;
        if (int'(clk_sel) < N_INT) begin
            tick = int_tick[clk_sel[1:0]];
        end else begin
            for (int e = 0; e < N_EXT; e++) begin
                if (int'(clk_sel) == N_INT + e)
                    tick = run && ext_evt[e];
            end
        end
    end
endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       clr_valid,
    output logic       run,
    output logic       periodic,
    output run_state_t state
);
    run_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_HALT;
        else
            state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HALT: begin
                if (start)
                    nxt = clr_valid ? ST_CYCLE : ST_FREE;   // GO_CYCLE / GO_FREE
            end
            ST_FREE, ST_CYCLE: begin
                if (!start)
                    nxt = ST_HALT;                          // STOP
                else
                    nxt = clr_valid ? ST_CYCLE : ST_FREE;   // RESELECT
            end
            default: nxt = ST_HALT;
        endcase
    end

    always_comb begin
        run      = 1'b0;
        periodic = 1'b0;
        unique case (state)
            ST_HALT:  ;
            ST_FREE:  run = 1'b1;
            ST_CYCLE: begin
                run      = 1'b1;
                periodic = 1'b1;
            end
            default:  ;
        endcase
    end

    // R2: writing start to 0 halts the channel on the next edge
    p_stop_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (state == ST_HALT));
endmodule

// File: rtl/tmr_gr_slot.sv
module tmr_gr_slot
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             tick,
    input  logic             wr_val,
    input  logic             wr_cfg,
    input  logic [CNT_W-1:0] wdata,
    input  logic             cap_pin,
    input  logic             flag_rd,
    input  logic             flag_wr,
    input  logic             flag_wbit,
    output logic [CNT_W-1:0] val,
    output logic [2:0]       cfg,
    output logic             match,
    output logic             flag,
    output logic             pin
);
    logic c1, c2, cp;
    logic cap_evt;
    cmp_act_t act;

    assign act   = cmp_act_t'(cfg[2:1]);
    assign match = tick && !cfg[0] && (count == val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1 <= 1'b0;
            c2 <= 1'b0;
            cp <= 1'b0;
        end else begin
            c1 <= cap_pin;
            c2 <= c1;
            cp <= c2;
        end
    end

    always_comb begin
        unique case (cfg[2:1])
            2'b01:   cap_evt = cfg[0] && c2 && !cp;
            2'b10:   cap_evt = cfg[0] && !c2 && cp;
            2'b11:   cap_evt = cfg[0] && (c2 ^ cp);
            default: cap_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val <= '0;
            cfg <= '0;
            pin <= 1'b0;
        end else begin
            if (cap_evt)
                val <= count;
            else if (wr_val)
                val <= wdata;

            if (wr_cfg)
                cfg <= wdata[2:0];

            if (match) begin
                unique case (act)
                    ACT_HOLD:   pin <= pin;
                    ACT_LOW:    pin <= 1'b0;
                    ACT_HIGH:   pin <= 1'b1;
                    ACT_TOGGLE: pin <= !pin;
                    default:    pin <= pin;
                endcase
            end
        end
    end

    tmr_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (match || cap_evt),
        .rd_i   (flag_rd),
        .wr_i   (flag_wr),
        .wbit_i (flag_wbit),
        .flag_o (flag)
    );

    // R9: a capture edge stores the counter value seen at that edge
    p_capture_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (val == $past(count)));
    // R8: drive-high action
    p_pin_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_HIGH) |=> pin);
    // R8: toggle action inverts the pin
    p_pin_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (match && act == ACT_TOGGLE) |=> (pin != $past(pin)));
    // R7: a match always leaves the flag set
    p_match_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int N_GR  = 4,
    parameter int N_EXT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic [N_EXT-1:0]  ext_clk,
    input  logic [N_GR-1:0]   cap_in,
    output logic [N_GR-1:0]   cmp_out
);
    logic [2:0] clk_sel;
    logic [1:0] edge_sel;
    logic [2:0] clr_sel;
    logic       start;
    logic [CNT_W-1:0] count;

    logic run, periodic, tick;
    run_state_t state;

    logic [N_GR-1:0][CNT_W-1:0] gr_val;
    logic [N_GR-1:0][2:0]       gr_cfg;
    logic [N_GR-1:0]            gr_match, gr_flag, clr_onehot;

    logic wr_cnt, flag_rd, flag_wr, clr_hit, clr_valid, ovf_set, ovf_flag;

    assign wr_cnt  = wr_en && (addr == A_COUNT);
    assign flag_rd = rd_en && (addr == A_FLAGS);
    assign flag_wr = wr_en && (addr == A_FLAGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_sel  <= '0;
            edge_sel <= '0;
            clr_sel  <= '0;
            start    <= 1'b0;
        end else if (wr_en) begin
            if (addr == A_CTRL)
                {clr_sel, edge_sel, clk_sel} <= wdata[7:0];
            if (addr == A_START)
                start <= wdata[0];
        end
    end

    generate
        for (genvar i = 0; i < N_GR; i++) begin : g_gr
            assign clr_onehot[i] = (clr_sel == 3'(i + 1));

            tmr_gr_slot #(.CNT_W(CNT_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .count     (count),
                .tick      (tick),
                .wr_val    (wr_en && (addr == A_VAL_BASE + ADDR_W'(i))),
                .wr_cfg    (wr_en && (addr == A_CFG_BASE + ADDR_W'(i))),
                .wdata     (wdata),
                .cap_pin   (cap_in[i]),
                .flag_rd   (flag_rd),
                .flag_wr   (flag_wr),
                .flag_wbit (wdata[i]),
                .val       (gr_val[i]),
                .cfg       (gr_cfg[i]),
                .match     (gr_match[i]),
                .flag      (gr_flag[i]),
                .pin       (cmp_out[i])
            );
        end
    endgenerate

    assign clr_valid = |clr_onehot;
    assign clr_hit   = periodic && |(gr_match & clr_onehot);
    assign ovf_set   = tick && !clr_hit && !wr_cnt && (&count);

    tmr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .clr_valid (clr_valid),
        .run       (run),
        .periodic  (periodic),
        .state     (state)
    );

    tmr_tick_gen #(.N_EXT(N_EXT)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .clk_sel  (clk_sel),
        .edge_sel (edge_sel),
        .ext_clk  (ext_clk),
        .tick     (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (wr_cnt)
            count <= wdata;
        else if (tick)
            count <= clr_hit ? '0 : count + 1'b1;
    end

    tmr_flag u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ovf_set),
        .rd_i   (flag_rd),
        .wr_i   (flag_wr),
        .wbit_i (wdata[CNT_W-1]),
        .flag_o (ovf_flag)
    );

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata[7:0] = {clr_sel, edge_sel, clk_sel};
            A_START: rdata[0] = start;
            A_FLAGS: begin
                rdata[N_GR-1:0]  = gr_flag;
                rdata[CNT_W-1]   = ovf_flag;
            end
            A_COUNT: rdata = count;
            default: begin
                for (int i = 0; i < N_GR; i++) begin
                    if (addr == A_VAL_BASE + ADDR_W'(i))
                        rdata = gr_val[i];
                    else if (addr == A_CFG_BASE + ADDR_W'(i))
                        rdata[2:0] = gr_cfg[i];
                end
            end
        endcase
    end

    // R2: every non-clearing tick adds exactly one
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr_hit && !wr_cnt) |=> (count == $past(count) + 1'b1));
    // R2: a halted channel holds its count
    p_hold_halted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(count));
    // R5: the clear-source match returns the counter to zero
    p_period_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !wr_cnt) |=> (count == '0));
    // R6: a wrap always raises the overflow flag
    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> (ovf_flag && count == '0));
endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  ext_clk = '0;
    logic [3:0]  cap_in = '0;
    logic [3:0]  cmp_out;

    int total = 0;
    int bad = 0;
    logic [15:0] rv;

    always #10 clk = !clk;

    tmr_channel u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .ext_clk(ext_clk), .cap_in(cap_in), .cmp_out(cmp_out)
    );

    // {clock select, idle clocks between start and stop, expected count}
    localparam int PRE_VEC [4][3] = '{
        '{0, 18, 20}, '{1, 38, 10}, '{2, 158, 10}, '{3, 318, 5}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic timed_run(input int k);
        wr(4'd1, 16'd1);
        repeat (k) @(negedge clk);
        wr(4'd1, 16'd0);
    endtask

    task automatic ext_pulses(input int idx, input int n);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            ext_clk[idx] = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk[idx] = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic clear_flags();
        rd(4'd2, rv);
        wr(4'd2, 16'h0000);
    endtask

    initial begin
        #(200000 * 20);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'd3, rv); check("R1 count", rv, 16'h0000);
        rd(4'd2, rv); check("R1 flags", rv, 16'h0000);
        check("R1 pins", {12'h0, cmp_out}, 16'h0000);

        // R3 table: prescaler ratios
        for (int v = 0; v < 4; v++) begin
            wr(4'd0, 16'(PRE_VEC[v][0]));
            wr(4'd3, 16'h0000);
            timed_run(PRE_VEC[v][1]);
            rd(4'd3, rv);
            check("R3 prescale", rv, 16'(PRE_VEC[v][2]));
        end
        repeat (10) @(negedge clk);
        rd(4'd3, rv); check("R2 hold after stop", rv, 16'd5);

        // R11: control readback
        wr(4'd0, 16'h0025);
        rd(4'd0, rv); check("R11 ctrl readback", rv, 16'h0025);

        // R5 R7 R8: periodic mode, GR0 period 4 toggle, GR1 drive high, GR2 drive low
        wr(4'd4, 16'd4); wr(4'd8, 16'd6);
        wr(4'd5, 16'd2); wr(4'd9, 16'd4);
        wr(4'd6, 16'd3); wr(4'd10, 16'd2);
        wr(4'd7, 16'd0); wr(4'd11, 16'd0);
        clear_flags();
        wr(4'd0, 16'h0020);
        wr(4'd3, 16'h0000);
        timed_run(15);
        rd(4'd3, rv); check("R5 period wrap", rv, 16'd2);
        #1 check("R8 toggle and drive high", {12'h0, cmp_out}, 16'h0003);
        rd(4'd2, rv); check("R7 match flags", rv, 16'h000F);

        // R8: drive-low action, R5 continue counting from 2
        wr(4'd8, 16'd2);
        timed_run(8);
        rd(4'd3, rv); check("R5 second run", rv, 16'd2);
        #1 check("R8 drive low", {15'h0, cmp_out[0]}, 16'h0000);

        // R6: overflow in free-running mode
        clear_flags();
        wr(4'd0, 16'h0000);
        wr(4'd3, 16'hFFFE);
        timed_run(0);
        rd(4'd3, rv); check("R6 wrap count", rv, 16'h0000);

        // R10: write of 0 without a prior read is ignored
        wr(4'd2, 16'h0000);
        rd(4'd2, rv); check("R6 R10 overflow flag kept", rv, 16'h8000);
        wr(4'd2, 16'h0000);
        rd(4'd2, rv); check("R10 cleared after read", rv, 16'h0000);

        // R9: capture GR3 rising, GR2 falling, while halted
        wr(4'd11, 16'd3);
        wr(4'd10, 16'd5);
        wr(4'd3, 16'h1234);
        @(negedge clk); cap_in = 4'b1100;
        repeat (5) @(negedge clk);
        rd(4'd7, rv); check("R9 rising capture", rv, 16'h1234);
        rd(4'd6, rv); check("R9 falling ignores rise", rv, 16'd3);
        wr(4'd3, 16'h0ABC);
        @(negedge clk); cap_in = 4'b0000;
        repeat (5) @(negedge clk);
        rd(4'd6, rv); check("R9 falling capture", rv, 16'h0ABC);
        rd(4'd7, rv); check("R9 rising ignores fall", rv, 16'h1234);
        rd(4'd2, rv); check("R9 capture flags", rv, 16'h000C);

        // R4: external clocks
        wr(4'd0, 16'h0004);
        wr(4'd3, 16'h0000);
        wr(4'd1, 16'd1);
        ext_pulses(0, 3);
        repeat (4) @(negedge clk);
        wr(4'd1, 16'd0);
        rd(4'd3, rv); check("R4 ext0 rising", rv, 16'd3);

        wr(4'd0, 16'h0014);
        wr(4'd3, 16'h0000);
        wr(4'd1, 16'd1);
        ext_pulses(0, 3);
        repeat (4) @(negedge clk);
        wr(4'd1, 16'd0);
        rd(4'd3, rv); check("R4 ext0 both edges", rv, 16'd6);

        wr(4'd0, 16'h000D);
        wr(4'd3, 16'h0000);
        wr(4'd1, 16'd1);
        ext_pulses(1, 3);
        ext_pulses(0, 2);
        repeat (4) @(negedge clk);
        wr(4'd1, 16'd0);
        rd(4'd3, rv); check("R4 ext1 falling only", rv, 16'd3);

        // R2: no counting while halted even with edges
        ext_pulses(1, 2);
        rd(4'd3, rv); check("R2 halted ignores ext", rv, 16'd3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule